// File: doc/BRIEF.md
# Fixed-Point Leaky Integrate-and-Fire Neuron

This block is one spiking neuron whose membrane state is a signed 16-bit value with 8 fraction bits. It runs one update on every rising clock edge. The update scales the held voltage by a leak factor and scales the input current by a gain factor. Both factors are Q8 fractions, so 256 means 1.0, 240 is about 0.94 and 16 is about 0.0625. An optional noise term is then added. The new value is compared against a firing threshold. When it reaches the threshold, the neuron emits a spike and loads a reset voltage in the same step.

Every intermediate result is wrapped to the 16-bit signed range and never saturated. Each product is formed at double width, shifted right arithmetically by the fraction width, and truncated to 16 bits. Both sums wrap modulo 2^16. These rules let a software model match the hardware bit for bit. Tie the noise input to zero for deterministic runs. The reset input is active low and asynchronous.

Top module: `lif_neuron`

## Requirements
- R1: While rst_ni is low, volt_o reads 0 and spike_o reads 0, without waiting for a clock edge.
- R2: The leak term is the 32-bit signed product of the held voltage and leak_i, shifted right arithmetically by 8 and truncated to 16 bits. With gain_i = 0 and noise_i = 0, leak_i = 0 gives volt_o = 0 after the next edge.
- R3: The gain term is the 32-bit signed product of current_i and gain_i, shifted right arithmetically by 8 and truncated to 16 bits. The shift rounds toward minus infinity, so current_i = -1 with gain_i = 1 gives -1. With leak_i = 0, noise_i = 0 and gain_i = 256, a current below the threshold appears unchanged on volt_o one edge later.
- R4: noise_i is a signed 16-bit value. It is added to the wrapped sum of the leak and gain terms.
- R5: Sums wrap modulo 2^16 and never saturate. For example, 200 + 32767 becomes -32569.
- R6: spike_o is 1 for exactly the step whose updated value, compared as a signed number, is at least THRESH (default 256).
- R7: On a step that spikes, volt_o holds V_RESET (default 0) after that same edge.
- R8: On a step that does not spike, spike_o is 0 and volt_o holds the updated value, which is below THRESH.
- R9: After reset is released, exactly one update happens per rising edge, using the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one neuron step per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| leak_i | input | 16 | Signed Q8 leak multiplier |
| gain_i | input | 16 | Signed Q8 gain multiplier |
| current_i | input | 16 | Signed Q8.8 input current |
| noise_i | input | 16 | Signed Q8.8 additive noise |
| spike_o | output | 1 | Spike flag for the last step |
| volt_o | output | 16 | Signed Q8.8 membrane voltage after the last step |

## Verification
The properties assume that the inputs are stable across each rising edge. The R2 and R3 checks fire only for particular input combinations: zero leak, zero gain and zero noise for R2, and unity gain with zero leak and zero noise for R3. The R8 property also assumes that V_RESET lies below THRESH. The bench changes inputs only on falling edges and keeps the default reset and threshold values. It compares every step against a wrapping reference model in the bench, and some directed steps land exactly on these combinations.

// File: rtl/lif_pkg.sv
package lif_pkg;
  parameter int unsigned QW = 16;
  parameter int unsigned QF = 8;
  localparam int unsigned PW = 2 * QW;

  typedef logic signed [QW-1:0] q_t;
  typedef logic signed [PW-1:0] p_t;

  localparam q_t Q_ONE = q_t'(1 << QF);

  typedef struct packed {
    logic spike;
    q_t   volt;
  } step_t;
endpackage

// File: rtl/lif_qmul.sv
// Q8 multiply: full-width product, arithmetic shift, wrap to QW bits
module lif_qmul
  import lif_pkg::*;
(
  input  q_t a_i,
  input  q_t b_i,
  output q_t y_o
);
  p_t prod;

  always_comb begin
    prod = p_t'(a_i) * p_t'(b_i);
    y_o  = q_t'(prod >>> QF);
  end
endmodule

// File: rtl/lif_wadd.sv
// Modular sum of N_TERMS operands; carries out of QW bits are dropped
module lif_wadd
  import lif_pkg::*;
#(
  parameter int unsigned N_TERMS = 3
) (
  input  q_t terms_i [N_TERMS],
  output q_t sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N_TERMS; i++) sum_o = sum_o + terms_i[i];
  end
endmodule

// File: rtl/lif_fire.sv
module lif_fire
  import lif_pkg::*;
#(
  parameter q_t THRESH  = Q_ONE,
  parameter q_t V_RESET = '0
) (
  input  q_t    sum_i,
  output step_t nxt_o
);
  always_comb begin
    nxt_o.spike = (sum_i >= THRESH);
    nxt_o.volt  = nxt_o.spike ? V_RESET : sum_i;
  end
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter q_t THRESH   = Q_ONE,
  parameter q_t V_RESET  = '0,
  parameter bit NOISE_EN = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [QW-1:0] leak_i,
  input  logic signed [QW-1:0] gain_i,
  input  logic signed [QW-1:0] current_i,
  input  logic signed [QW-1:0] noise_i,
  output logic                 spike_o,
  output logic signed [QW-1:0] volt_o
);
  localparam int unsigned N_TERMS = NOISE_EN ? 3 : 2;

  q_t    volt_q;
  q_t    leak_term;
  q_t    gain_term;
  q_t    sum;
  q_t    terms [N_TERMS];
  step_t nxt;
  logic  spike_q;

  lif_qmul u_leak_mul (.a_i(volt_q),    .b_i(leak_i), .y_o(leak_term));
  lif_qmul u_gain_mul (.a_i(current_i), .b_i(gain_i), .y_o(gain_term));

  assign terms[0] = leak_term;
  assign terms[1] = gain_term;

  generate
    if (NOISE_EN) begin : g_noise
      assign terms[2] = noise_i;
    end else begin : g_no_noise
      logic unused_noise;
      assign unused_noise = ^noise_i;
    end
  endgenerate

  lif_wadd #(.N_TERMS(N_TERMS)) u_sum (.terms_i(terms), .sum_o(sum));

  lif_fire #(.THRESH(THRESH), .V_RESET(V_RESET)) u_fire (.sum_i(sum), .nxt_o(nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      volt_q  <= '0;
      spike_q <= 1'b0;
    end else begin
      volt_q  <= nxt.volt;
      spike_q <= nxt.spike;
    end
  end

  assign volt_o  = volt_q;
  assign spike_o = spike_q;
endmodule

// File: rtl/lif_neuron_chk.sv
module lif_neuron_chk
  import lif_pkg::*;
#(
  parameter q_t THRESH  = Q_ONE,
  parameter q_t V_RESET = '0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic signed [QW-1:0] leak_i,
  input logic signed [QW-1:0] gain_i,
  input logic signed [QW-1:0] current_i,
  input logic signed [QW-1:0] noise_i,
  input logic                 spike_o,
  input logic signed [QW-1:0] volt_o
);
  // R7
  spike_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_o |-> volt_o == V_RESET);

  // R8
  below_thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spike_o |-> volt_o < THRESH);

  // R2
  zero_leak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leak_i == '0 && gain_i == '0 && noise_i == '0) |=> (volt_o == '0 && !spike_o));

  // R3
  unity_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leak_i == '0 && noise_i == '0 && gain_i == Q_ONE && current_i < THRESH)
      |=> (volt_o == $past(current_i) && !spike_o));
endmodule

bind lif_neuron lif_neuron_chk #(.THRESH(THRESH), .V_RESET(V_RESET)) chk_i (.*);

// File: tb/lif_neuron_tb_top.sv
`timescale 1ns/1ps
module lif_neuron_tb_top;
  localparam int THR = 256;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [15:0] leak_i = '0, gain_i = '0, current_i = '0, noise_i = '0;
  logic               spike_o;
  logic signed [15:0] volt_o;

  int n_chk = 0, n_fail = 0;
  logic signed [15:0] m_v = '0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  lif_neuron dut_i (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference step: 32-bit products, >>>8, wrap each value to 16 bits
  task automatic step(input int lk, input int gn, input int cur, input int nz, input string req);
    int p1, p2;
    logic signed [15:0] lt, gt, s;
    bit sp;
    @(negedge clk_i);
    leak_i = 16'(lk); gain_i = 16'(gn); current_i = 16'(cur); noise_i = 16'(nz);
    p1 = int'(m_v) * int'(leak_i);
    p2 = int'(current_i) * int'(gain_i);
    lt = 16'(p1 >>> 8);
    gt = 16'(p2 >>> 8);
    s  = lt + gt + noise_i;
    sp = (int'(s) >= THR);
    m_v = sp ? 16'sd0 : s;
    @(posedge clk_i); #1;
    check({req, " spike"}, int'(spike_o), int'(sp));
    check({req, " volt"}, int'(volt_o), int'(m_v));
  endtask

  task automatic t_reset;
    rst_ni = 0;
    #1;
    check("R1 spike", int'(spike_o), 0);
    check("R1 volt", int'(volt_o), 0);
    m_v = '0;
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic t_leak;
    step(0, 256, 200, 0, "R3");
    step(240, 0, 0, 0, "R2");
    step(240, 0, 0, 0, "R2");
    check("R2 decay", int'(volt_o), 175);
    step(0, 0, 0, 0, "R2");
  endtask

  task automatic t_gain;
    step(0, 1, -1, 0, "R3");
    check("R3 floor", int'(volt_o), -1);
    step(0, 16, -50, 0, "R3");
    step(240, 16, 99, 0, "R3");
  endtask

  task automatic t_noise;
    step(0, 256, 100, 50, "R4");
    check("R4 sum", int'(volt_o), 150);
    step(256, 0, 0, -30, "R4");
  endtask

  task automatic t_wrap;
    step(0, 256, 200, 32767, "R5");
    check("R5 wrap", int'(volt_o), -32569);
    step(0, 256, -32768, -1, "R5");
    check("R5 spike", int'(spike_o), 1);
  endtask

  task automatic t_fire;
    step(0, 256, 255, 0, "R8");
    check("R8 volt", int'(volt_o), 255);
    step(256, 256, 1, 0, "R6");
    check("R6 edge", int'(spike_o), 1);
    check("R7 volt", int'(volt_o), 0);
    step(0, 256, 256, 0, "R7");
  endtask

  task automatic t_rate;
    for (int i = 0; i < 3; i++) step(256, 256, 10, 0, "R9");
    check("R9 count", int'(volt_o), 30);
    for (int i = 0; i < 40; i++) step(240, 16, 300 + i * 37, (i % 5) - 2, "R9");
  endtask

  initial begin
    t_reset();
    t_leak();
    t_gain();
    t_noise();
    t_wrap();
    t_fire();
    t_rate();
    step(256, 256, 40, 0, "R9");
    t_reset();
    step(0, 256, 12, 0, "R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule